// File: doc/BRIEF.md
# Phase-Accumulator Waveform Oscillator

A single audio voice oscillator. A 24-bit phase register advances by a 16-bit frequency word on every clock and wraps silently. The block shapes the upper bits of that phase into a 12-bit sample. A 4-bit select input picks one of three basic waveforms, or silence: a rising ramp, a folded (triangle) ramp, or a two-level pulse whose duty cycle is set by a 12-bit width value.

A freeze input stops the oscillator. While it is high the phase is held at zero and the pulse level is forced to full scale. The phase starts again from zero once the input drops. A ring-modulation input lets the top phase bit of a partner oscillator flip the fold point of the triangle. The block exports its own top phase bit, and a one-cycle strobe for the cycle in which that bit rises, so that neighbouring oscillators and sync logic can use them. Any selection that has more than one waveform bit set, or the noise bit set, produces silence.

Top module: `wave_osc`

## Requirements
- R1: On each clock without freeze, the 24-bit phase becomes (phase + freq_word) modulo 2^24. `phase_msb` shows bit 23 of the phase register.
- R2: While `freeze` is high, the phase is loaded with zero and stays there. After `freeze` drops, the phase counts up again from zero.
- R3: `wave_out` is registered. It shows the waveform computed from the phase value and the control inputs that were present at the previous clock edge.
- R4: Ramp (select 4'b0010) outputs phase bits [23:12].
- R5: Triangle (select 4'b0001) outputs phase bits [22:11], bitwise inverted when the fold bit is 1. With `ring_en` low, the fold bit is phase bit 23.
- R6: With `ring_en` high, the triangle fold bit is phase bit 23 XOR `partner_msb`.
- R7: Pulse (select 4'b0100) outputs 12'hFFF when phase bits [23:12] >= `pulse_width`, and 12'h000 otherwise.
- R8: While `freeze` is high, pulse outputs 12'hFFF whatever `pulse_width` is.
- R9: `msb_rise` is high for exactly the cycle after the edge at which phase bit 23 changes from 0 to 1. Otherwise it is low.
- R10: Select 4'b0000 outputs zero. Any select with bit 3 (noise) set or with more than one bit set also outputs zero.
- R11: A synchronous active-high reset clears the phase, `wave_out` and `msb_rise`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 16 | Phase increment added each clock |
| pulse_width | input | 12 | Pulse threshold compared with phase bits [23:12] |
| wave_sel | input | 4 | Waveform select: bit0 triangle, bit1 ramp, bit2 pulse, bit3 noise |
| freeze | input | 1 | Holds the phase at zero and forces the pulse level high |
| ring_en | input | 1 | Lets the partner MSB flip the triangle fold |
| partner_msb | input | 1 | Top phase bit of the partner oscillator |
| wave_out | output | 12 | Registered waveform sample |
| phase_msb | output | 1 | Bit 23 of the phase register |
| msb_rise | output | 1 | One-cycle strobe when bit 23 rises |

## Verification
Some properties are checked on every cycle:
- The freeze input empties the phase, and the phase otherwise advances by exactly the frequency word.
- The rise strobe appears only together with a fresh 0-to-1 transition of the top bit.
- The pulse select yields only the two rail values, and it is full scale while frozen.
- Mixed and noise selections stay silent.

The exact sample values need the bench's scenarios: triangle folding with and without ring modulation, the pulse threshold at its equal-to boundary, the restart from zero after a freeze, and the wrap of the phase through 2^24.

// File: rtl/wave_osc_pkg.sv
package wave_osc_pkg;

    localparam int PHASE_W_DEF = 24;
    localparam int STEP_W_DEF  = 16;
    localparam int SAMPLE_W_DEF = 12;
    localparam int SEL_W       = 4;

    typedef enum logic [1:0] {
        WK_SILENT,
        WK_TRIANGLE,
        WK_RAMP,
        WK_PULSE
    } wave_kind_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             freeze;
        logic             ring;
        logic             partner;
    } wave_ctrl_t;

    // Only single-waveform selections produce a sample; all others are silent.
    function automatic wave_kind_e decode_sel(input logic [SEL_W-1:0] sel);
        wave_kind_e k;
        case (sel)
            4'b0001: k = WK_TRIANGLE;
            4'b0010: k = WK_RAMP;
            4'b0100: k = WK_PULSE;
            default: k = WK_SILENT;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/osc_phase_acc.sv
module osc_phase_acc
    import wave_osc_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF,
    parameter int STEP_W  = STEP_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STEP_W-1:0]  step,
    input  logic               freeze,
    output logic [PHASE_W-1:0] phase,
    output logic               rise
);
    localparam int PAD_W = PHASE_W - STEP_W;

    logic [PHASE_W-1:0] phase_next;

    always_comb begin
        if (freeze)
            phase_next = '0;
        else
            phase_next = phase + {{PAD_W{1'b0}}, step};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            rise  <= 1'b0;
        end else begin
            phase <= phase_next;
            rise  <= !phase[PHASE_W-1] && phase_next[PHASE_W-1];
        end
    end

    AST_FREEZE_ZERO: assert property (@(posedge clk) disable iff (rst)
        freeze |=> (phase == '0)); // R2

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !freeze |=> (phase == PHASE_W'($past(phase) + {{PAD_W{1'b0}}, $past(step)}))); // R1

    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (rst)
        rise |-> (phase[PHASE_W-1] && !$past(phase[PHASE_W-1]))); // R9

endmodule

// File: rtl/osc_wave_shaper.sv
module osc_wave_shaper
    import wave_osc_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W:0]   top_phase,
    input  wave_ctrl_t          ctrl,
    input  logic [SAMPLE_W-1:0] width,
    output logic [SAMPLE_W-1:0] sample
);
    logic                fold;
    logic [SAMPLE_W-1:0] tri_w;
    logic [SAMPLE_W-1:0] ramp_w;
    logic                pulse_hi;
    logic [SAMPLE_W-1:0] shaped;
    wave_kind_e          kind;

    always_comb begin
        fold     = top_phase[SAMPLE_W] ^ (ctrl.ring & ctrl.partner);
        tri_w    = fold ? ~top_phase[SAMPLE_W-1:0] : top_phase[SAMPLE_W-1:0];
        ramp_w   = top_phase[SAMPLE_W:1];
        pulse_hi = ctrl.freeze || (ramp_w >= width);
        kind     = decode_sel(ctrl.sel);
        case (kind)
            WK_TRIANGLE: shaped = tri_w;
            WK_RAMP:     shaped = ramp_w;
            WK_PULSE:    shaped = {SAMPLE_W{pulse_hi}};
            default:     shaped = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            sample <= '0;
        else
            sample <= shaped;
    end

    AST_PULSE_RAILS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel == 4'b0100) |=> (sample == '0 || sample == '1)); // R7

    AST_FREEZE_PULSE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel == 4'b0100 && ctrl.freeze) |=> (sample == '1)); // R8

    AST_MIXED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel[3] || $countones(ctrl.sel) != 1) |=> (sample == '0)); // R10

endmodule

// File: rtl/wave_osc.sv
module wave_osc
    import wave_osc_pkg::*;
#(
    parameter int PHASE_W  = PHASE_W_DEF,
    parameter int STEP_W   = STEP_W_DEF,
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STEP_W-1:0]   freq_word,
    input  logic [SAMPLE_W-1:0] pulse_width,
    input  logic [SEL_W-1:0]    wave_sel,
    input  logic                freeze,
    input  logic                ring_en,
    input  logic                partner_msb,
    output logic [SAMPLE_W-1:0] wave_out,
    output logic                phase_msb,
    output logic                msb_rise
);
    logic [PHASE_W-1:0] phase;
    wave_ctrl_t         ctrl;

    assign ctrl = '{sel: wave_sel, freeze: freeze, ring: ring_en, partner: partner_msb};

    osc_phase_acc #(.PHASE_W(PHASE_W), .STEP_W(STEP_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .step   (freq_word),
        .freeze (freeze),
        .phase  (phase),
        .rise   (msb_rise)
    );

    osc_wave_shaper #(.SAMPLE_W(SAMPLE_W)) u_shape (
        .clk       (clk),
        .rst       (rst),
        .top_phase (phase[PHASE_W-1 -: SAMPLE_W+1]),
        .ctrl      (ctrl),
        .width     (pulse_width),
        .sample    (wave_out)
    );

    assign phase_msb = phase[PHASE_W-1];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (wave_out == '0 && !msb_rise && !phase_msb)); // R11

endmodule

// File: tb/wave_osc_bench.sv
module wave_osc_bench;

    typedef struct {
        logic [11:0] wave;
        logic        msb;
        logic        rise;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] freq_word = '0;
    logic [11:0] pulse_width = '0;
    logic [3:0]  wave_sel = '0;
    logic        freeze = 1'b0;
    logic        ring_en = 1'b0;
    logic        partner_msb = 1'b0;
    logic [11:0] wave_out;
    logic        phase_msb;
    logic        msb_rise;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t sb[$];
    logic [23:0] m_phase = '0;

    always #10 clk = ~clk;

    wave_osc u_wave_osc (
        .clk(clk), .rst(rst), .freq_word(freq_word), .pulse_width(pulse_width),
        .wave_sel(wave_sel), .freeze(freeze), .ring_en(ring_en),
        .partner_msb(partner_msb), .wave_out(wave_out),
        .phase_msb(phase_msb), .msb_rise(msb_rise)
    );

    function automatic logic [11:0] model_wave(input logic [23:0] ph);
        logic f;
        logic [11:0] t;
        f = ph[23] ^ (ring_en & partner_msb);
        t = f ? ~ph[22:11] : ph[22:11];
        case (wave_sel)
            4'b0001: return t;
            4'b0010: return ph[23:12];
            4'b0100: return (freeze || ph[23:12] >= pulse_width) ? 12'hFFF : 12'h000;
            default: return 12'h000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: called at a falling edge; queues what the next rising edge must produce.
    task automatic step(input string tag);
        exp_t e;
        logic [23:0] nxt;
        nxt = freeze ? 24'h0 : m_phase + {8'h0, freq_word};
        e.wave = model_wave(m_phase);
        e.msb  = nxt[23];
        e.rise = !m_phase[23] && nxt[23];
        e.tag  = tag;
        sb.push_back(e);
        m_phase = nxt;
        @(negedge clk);
    endtask

    // Monitor: samples 5 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {20'h0, wave_out}, {20'h0, e.wave});
                check("R1 phase_msb", {31'h0, phase_msb}, {31'h0, e.msb});
                check("R9 msb_rise", {31'h0, msb_rise}, {31'h0, e.rise});
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        m_phase = '0;
        @(negedge clk);
        @(negedge clk);
        check("R11 wave_out after reset", {20'h0, wave_out}, 32'h0);
        check("R11 phase_msb after reset", {31'h0, phase_msb}, 32'h0);
        check("R11 msb_rise after reset", {31'h0, msb_rise}, 32'h0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // Ramp across several wraps
        wave_sel = 4'b0010; freq_word = 16'hFFFF;
        for (int i = 0; i < 600; i++) step("R4 ramp / R1 wrap / R3 latency");

        // Triangle without ring modulation
        wave_sel = 4'b0001; freq_word = 16'hF123;
        for (int i = 0; i < 400; i++) step("R5 triangle");

        // Triangle with ring modulation and a toggling partner
        ring_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            partner_msb = i[3];
            step("R6 ring triangle");
        end
        ring_en = 1'b0; partner_msb = 1'b0;

        // Freeze: phase held at zero, ramp silent
        wave_sel = 4'b0010; freeze = 1'b1;
        for (int i = 0; i < 8; i++) step("R2 freeze ramp");
        // Freeze with pulse at maximum width: forced high
        wave_sel = 4'b0100; pulse_width = 12'hFFF;
        for (int i = 0; i < 6; i++) step("R8 freeze pulse");
        // Release: unit step in the upper bits, exact threshold crossing
        freeze = 1'b0; freq_word = 16'h1000; pulse_width = 12'h005;
        for (int i = 0; i < 12; i++) step("R7 pulse threshold / R2 restart");
        pulse_width = 12'h000;
        for (int i = 0; i < 6; i++) step("R7 pulse width zero");
        wave_sel = 4'b0010;
        for (int i = 0; i < 6; i++) step("R2 restart ramp");

        // Silent selections
        freq_word = 16'hFFFF;
        for (int s = 0; s < 16; s++) begin
            wave_sel = 4'(s);
            for (int i = 0; i < 20; i++) step("R10 select encoding");
        end

        // Mid-run reset
        wave_sel = 4'b0010;
        for (int i = 0; i < 4; i++) @(negedge clk);
        do_reset();
        for (int i = 0; i < 10; i++) step("R11 restart after reset");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule